// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the module clock into CAN bit timing. A 16-bit configuration word sets four things: a clock prescaler that produces the time quantum, the length of the phase before the sample point, the length of the phase after it, and the largest correction allowed at each resynchronisation. Each nominal bit is built from a single synchronisation quantum, then the first phase, then the second phase. The block raises a one-clock strobe when the sample point is reached and another one at the end of the bit.

The receive line passes through a two-flop synchroniser. A recessive-to-dominant transition that falls inside the first phase makes that phase longer. A transition that falls inside the second phase makes that phase shorter. Either correction is limited by the jump width, and only one correction is made between two sample points. The configuration word can be written only while both the change-enable input and the init input are high. While init is high the bit sequencer is held idle. When init is released, timing starts again from the synchronisation quantum.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word has the prescaler in bits 5:0, the jump width in bits 7:6, the first phase in bits 11:8 and the second phase in bits 14:12. Bit 15 is always stored and read as 0. After reset the word is 0x2301.
- R2: One time quantum lasts prescaler field + 1 module clocks.
- R3: A bit lasts 1 + (first-phase field + 1) + (second-phase field + 1) quanta. sample_o pulses at the end of the first phase and bit_end_o pulses at the end of the second phase.
- R4: A falling receive edge detected in the first phase at quantum index q (0-based) lengthens that phase by min(q + 1, jump field + 1) quanta.
- R5: A falling receive edge detected in the second phase at index q shortens that phase by min(length − q, jump field + 1) quanta. The phase never ends before the current quantum.
- R6: At most one correction is made between two sample points; later edges are ignored. An edge detected during the synchronisation quantum causes no correction.
- R7: The receive input reaches edge detection through two flops. A level driven just after clock edge N is acted on at edge N+3.
- R8: A write on wr_data is stored only when wr_en, cfg_en and init are all high. Otherwise the stored word is unchanged.
- R9: While init is high no strobe is produced. Counting restarts from the synchronisation quantum, and the first quantum ends prescaler + 1 clocks after the first edge at which init is seen low.
- R10: Both strobes are registered one-clock pulses. Each appears in the clock after a quantum tick, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Holds the sequencer idle; also needed for writes |
| cfg_en | input | 1 | Configuration change enable |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 16 | Configuration word to write |
| cfg_q | output | 16 | Stored configuration word |
| rx | input | 1 | Receive line, 1 = recessive |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | End-of-bit strobe |

## Verification
Two functions can fall in the same cycle: the quantum that would end the first phase (and so raise sample_o), and a resynchronisation that lengthens that phase. The bench provokes this by dropping rx so that its synchronised edge lands in the last quantum of the first phase. With the widest jump width this must move the sample point from edge 13 to edge 17, not produce a sample first. A second case times an edge into the first quantum of the second phase. There the shortened phase must end in that same quantum, so bit_end_o appears at edge 14 and not edge 16.

// File: rtl/can_bt_pkg.sv
// Package: shared configuration layout and sequencer state for the CAN
// bit timing generator. Assumes the 16-bit word layout fixed by R1.
package can_bt_pkg;
    localparam int CFG_W   = 16;
    localparam int BRP_W   = 6;
    localparam int SJW_W   = 2;
    localparam int T1_W    = 4;
    localparam int T2_W    = 3;
    localparam logic [CFG_W-1:0] CFG_RST  = 16'h2301;
    localparam logic [CFG_W-1:0] CFG_MASK = 16'h7FFF;

    typedef struct packed {
        logic              rsvd;
        logic [T2_W-1:0]   tseg2;
        logic [T1_W-1:0]   tseg1;
        logic [SJW_W-1:0]  sjw;
        logic [BRP_W-1:0]  brp;
    } cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;
endpackage

// File: rtl/can_bt_cfg_reg.sv
// Configuration register. Holds the timing word and accepts a write only
// while both cfg_en and init are high. Bit 15 is forced to zero.
module can_bt_cfg_reg
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             cfg_en,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg
);
    // Load the reset word, or a gated write with the reserved bit cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= cfg_t'(CFG_RST);
        else if (wr_en && cfg_en && init)
            cfg <= cfg_t'(wr_data & CFG_MASK);
    end
endmodule

// File: rtl/can_bt_prescaler.sv
// Quantum prescaler. Raises tq for one clock every div+1 clocks. It is
// held at count zero while init is high, so the first tick after release
// comes div+1 clocks later.
module can_bt_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic [W-1:0] div,
    output logic         tq
);
    logic [W-1:0] cnt;

    assign tq = !init && (cnt == div);

    // Count clocks within a quantum and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || init || tq)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/can_bt_rx_sync.sv
// Receive synchroniser and falling-edge detector. STAGES flops bring rx
// into the clock domain. One more flop keeps the previous level. All
// flops reset to recessive, so no false edge appears after reset.
module can_bt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    output logic fall
);
    logic [STAGES:0] sh;

    // Shift the raw line through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '1;
        else
            sh <= {sh[STAGES-1:0], rx};
    end

    assign fall = sh[STAGES] && !sh[STAGES-1];
endmodule

// File: rtl/can_bt_seq.sv
// Bit segment sequencer. Steps sync -> first phase -> second phase on
// quantum ticks. It applies one resynchronisation per sample interval,
// limited to the jump width, and drives registered strobes. It assumes
// tseg1 >= 1, and that a fall pulse lasts one clock.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int P1_W = 4,
    parameter int P2_W = 3,
    parameter int J_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            tq,
    input  logic            fall,
    input  logic [P1_W-1:0] tseg1,
    input  logic [P2_W-1:0] tseg2,
    input  logic [J_W-1:0]  sjw,
    output logic            sample_o,
    output logic            bit_end_o
);
    localparam int L1_W = P1_W + 2;
    localparam int L2_W = P2_W + 1;

    seg_e              seg;
    logic [L1_W-1:0]   qcnt;
    logic [L1_W-1:0]   len1, len1_n, err1, ext1, jump;
    logic [L2_W-1:0]   len2, len2_n, rem2, cut2, jump2;
    logic              resynced, adj1, adj2, last1, last2;

    // Work out the phase corrections and end-of-phase conditions.
    always_comb begin
        jump   = L1_W'(sjw) + L1_W'(1);
        jump2  = L2_W'(jump);
        adj1   = fall && (seg == SEG_ONE) && !resynced;
        adj2   = fall && (seg == SEG_TWO) && !resynced;
        err1   = qcnt + L1_W'(1);
        ext1   = (err1 < jump) ? err1 : jump;
        len1_n = adj1 ? (len1 + ext1) : len1;
        rem2   = len2 - L2_W'(qcnt);
        cut2   = (rem2 < jump2) ? rem2 : jump2;
        len2_n = adj2 ? (len2 - cut2) : len2;
        last1  = (qcnt + L1_W'(1)) >= len1_n;
        last2  = (qcnt + L1_W'(1)) >= L1_W'(len2_n);
    end

    // Advance segments on quantum ticks and emit one-clock strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            seg       <= SEG_SYNC;
            qcnt      <= '0;
            len1      <= L1_W'(tseg1) + L1_W'(1);
            len2      <= L2_W'(tseg2) + L2_W'(1);
            resynced  <= 1'b0;
            sample_o  <= 1'b0;
            bit_end_o <= 1'b0;
        end else begin
            sample_o  <= 1'b0;
            bit_end_o <= 1'b0;
            len1      <= len1_n;
            len2      <= len2_n;
            if (adj1 || adj2)
                resynced <= 1'b1;
            if (tq) begin
                case (seg)
                    SEG_SYNC: begin
                        seg  <= SEG_ONE;
                        qcnt <= '0;
                        len1 <= L1_W'(tseg1) + L1_W'(1);
                    end
                    SEG_ONE: begin
                        if (last1) begin
                            seg      <= SEG_TWO;
                            qcnt     <= '0;
                            len2     <= L2_W'(tseg2) + L2_W'(1);
                            resynced <= 1'b0;
                            sample_o <= 1'b1;
                        end else begin
                            qcnt <= qcnt + L1_W'(1);
                        end
                    end
                    SEG_TWO: begin
                        if (last2) begin
                            seg       <= SEG_SYNC;
                            qcnt      <= '0;
                            bit_end_o <= 1'b1;
                        end else begin
                            qcnt <= qcnt + L1_W'(1);
                        end
                    end
                    default: seg <= SEG_SYNC;
                endcase
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// Top of the CAN bit timing generator: configuration register, quantum
// prescaler, receive synchroniser and segment sequencer. It assumes rx
// is asynchronous and idles recessive (1).
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             cfg_en,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             rx,
    output logic             sample_o,
    output logic             bit_end_o
);
    cfg_t cfg;
    logic tq;
    logic fall;

    assign cfg_q = cfg;

    can_bt_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .init(init), .cfg_en(cfg_en),
        .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg)
    );

    can_bt_prescaler #(.W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .init(init), .div(cfg.brp), .tq(tq)
    );

    can_bt_rx_sync #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx(rx), .fall(fall)
    );

    can_bt_seq #(.P1_W(T1_W), .P2_W(T2_W), .J_W(SJW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .init(init), .tq(tq), .fall(fall),
        .tseg1(cfg.tseg1), .tseg2(cfg.tseg2), .sjw(cfg.sjw),
        .sample_o(sample_o), .bit_end_o(bit_end_o)
    );
endmodule

// File: rtl/can_bt_chk.sv
// Checker for can_bit_timer, attached by bind. It watches the write
// gating, the init hold and the strobe timing against the quantum tick.
module can_bt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        init,
    input logic        cfg_en,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] cfg_q,
    input logic        tq,
    input logic        sample_o,
    input logic        bit_end_o
);
    a_r8_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_en && init) |=> (cfg_q == {1'b0, $past(wr_data[14:0])}));

    a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && cfg_en && init)) |=> $stable(cfg_q));

    a_r9_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!sample_o && !bit_end_o));

    a_r10_strobe_after_tq: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o || bit_end_o) |-> $past(tq));

    a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && bit_end_o));
endmodule

bind can_bit_timer can_bt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init(init), .cfg_en(cfg_en),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q), .tq(tq),
    .sample_o(sample_o), .bit_end_o(bit_end_o)
);

// File: tb/sim_can_bit_timer.sv
// Bench for can_bit_timer: a configuration table walked by one loop, then
// directed tests of reset, write gating, init hold and resynchronisation.
module sim_can_bit_timer;
    localparam int CLK_P = 10;
    localparam int NV = 5;
    // {config word, first sample edge, first bit-end edge}
    localparam int VEC [NV][3] = '{
        '{32'h2301, 10, 16},
        '{32'h0100, 3, 4},
        '{32'h7F3F, 1088, 1600},
        '{32'h1504, 35, 45},
        '{32'h45C2, 21, 36}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init = 1'b1;
    logic cfg_en = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cfg_q;
    logic rx = 1'b1;
    logic sample_o, bit_end_o;

    int tests = 0;
    int fails = 0;
    int s_at [3];
    int e_at [3];
    int both_hi;

    always #(CLK_P/2) clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .init(init), .cfg_en(cfg_en),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q), .rx(rx),
        .sample_o(sample_o), .bit_end_o(bit_end_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] val, input logic en, input logic ini);
        @(posedge clk); #1;
        init = ini; cfg_en = en; wr_en = 1'b1; wr_data = val;
        @(posedge clk); #1;
        wr_en = 1'b0; cfg_en = 1'b0;
    endtask

    // Write a word with init high, release init at edge 0, then count edges,
    // log strobe edges and drive rx low/high/low after the given edges.
    task automatic run_bits(input logic [15:0] val, input int n,
                            input int lo1, input int hi1, input int lo2);
        write_cfg(val, 1'b1, 1'b1);
        rx = 1'b1;
        @(posedge clk); #1;
        init = 1'b0;
        for (int i = 0; i < 3; i++) begin s_at[i] = -1; e_at[i] = -1; end
        both_hi = 0;
        begin
            int ns, ne;
            ns = 0; ne = 0;
            for (int e = 1; e <= n; e++) begin
                @(posedge clk); #1;
                if (sample_o && bit_end_o) both_hi++;
                if (sample_o && ns < 3) begin s_at[ns] = e; ns++; end
                if (bit_end_o && ne < 3) begin e_at[ne] = e; ne++; end
                if (e == lo1) rx = 1'b0;
                if (e == hi1) rx = 1'b1;
                if (e == lo2) rx = 1'b0;
            end
        end
        rx = 1'b1;
        @(posedge clk); #1;
        init = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset word", int'(cfg_q), 32'h2301);
        chk("R10 no strobe in reset", int'(sample_o | bit_end_o), 0);

        // Reset word used without a write: 500 kbit/s timing at prescale 2.
        @(posedge clk); #1;
        init = 1'b0;
        begin
            int first_s;
            first_s = -1;
            for (int e = 1; e <= 12; e++) begin
                @(posedge clk); #1;
                if (sample_o && first_s < 0) first_s = e;
            end
            chk("R1 reset timing sample edge", first_s, 10);
        end
        @(posedge clk); #1 init = 1'b1;

        // Table walk over several configurations.
        for (int v = 0; v < NV; v++) begin
            run_bits(16'(VEC[v][0]), VEC[v][2] + VEC[v][1] + 2, -1, -1, -1);
            chk("R8 write readback", int'(cfg_q), VEC[v][0]);
            chk("R2 R3 first sample edge", s_at[0], VEC[v][1]);
            chk("R3 first bit end edge", e_at[0], VEC[v][2]);
            chk("R3 second sample edge", s_at[1], VEC[v][2] + VEC[v][1]);
            chk("R10 strobes exclusive", both_hi, 0);
        end

        // Write gating and reserved bit.
        write_cfg(16'hFFFF, 1'b1, 1'b1);
        chk("R1 reserved bit reads zero", int'(cfg_q), 32'h7FFF);
        write_cfg(16'h1234, 1'b0, 1'b1);
        chk("R8 write ignored cfg_en low", int'(cfg_q), 32'h7FFF);
        write_cfg(16'h1234, 1'b1, 1'b0);
        chk("R8 write ignored init low", int'(cfg_q), 32'h7FFF);
        @(posedge clk); #1 init = 1'b1;

        // Init hold: no strobes for many cycles.
        begin
            int cnt;
            cnt = 0;
            for (int e = 0; e < 40; e++) begin
                @(posedge clk); #1;
                if (sample_o || bit_end_o) cnt++;
            end
            chk("R9 no strobes while init", cnt, 0);
        end

        // Resync, brp 0, tseg1 3, tseg2 2, sjw 1: plain bit1 sample 13 end 16.
        run_bits(16'h2340, 24, 9, -1, -1);
        chk("R4 R7 lengthen capped sample", s_at[1], 15);
        chk("R4 lengthen bit end", e_at[1], 18);

        run_bits(16'h2340, 24, 11, -1, -1);
        chk("R5 R7 shorten bit end", e_at[1], 14);
        chk("R5 next sample after shorten", s_at[2], 19);

        run_bits(16'h2340, 24, 7, 8, 9);
        chk("R6 second edge ignored sample", s_at[1], 14);
        chk("R6 second edge ignored end", e_at[1], 17);

        run_bits(16'h2340, 24, 6, -1, -1);
        chk("R6 edge in sync quantum sample", s_at[1], 13);
        chk("R6 edge in sync quantum end", e_at[1], 16);

        // Coincidence: edge in last first-phase quantum with sjw 3.
        run_bits(16'h23C0, 24, 10, -1, -1);
        chk("R4 edge at sample quantum", s_at[1], 17);
        chk("R4 bit end after coincidence", e_at[1], 20);
        chk("R10 strobes exclusive resync", both_hi, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule